// File: doc/BRIEF.md
# Control Endpoint OUT Receive Buffer

This block is the receive side of a USB function's control endpoint while a control transfer is in its host-to-device data stage. A packet engine gives it OUT, IN and SETUP token strobes and a byte stream. The stream has a start marker, per-byte valid and a separate end marker that carries a good/bad packet indication. For every good data packet the block answers with an ACK or NAK handshake code.

Firmware first decodes the setup command. It then tells the block that the data stage runs in the OUT direction. After that, each OUT packet either lands in an 8-byte buffer or is refused. The decision depends on whether firmware has released the previous packet. A packet lands only if the buffer is "armed". Arming comes back only through an explicit read-complete write; clearing the receive flag does not restore it. Firmware reads the byte count and pulls the bytes in order through one data port. An interrupt request follows the receive flag when enabled. An IN token during the OUT stage moves the stage tracker to the status stage.

Top module: `ep0_out_rxbuf`

## Requirements
- R1: After reset the buffer holds zero bytes and is armed, the receive flag is 0, the stage reads idle (0) and `irq` is low.
- R2: OUT data-stage handling starts only after a write of 1 to bit 0 at address 0. The stage field (address 0 read, bits 3:2; 0 idle, 1 OUT, 2 status) then reads 1. While the stage is not OUT, an OUT packet gets no handshake and nothing is stored.
- R3: An armed buffer that receives a good packet of 0 to 8 bytes raises `hs_valid` with `hs_code`=2'b01 (ACK) in the cycle after the end marker. The same packet sets the receive flag (address 1 read, bit 0), loads the byte count (address 3) and disarms the buffer (address 1 read, bit 1).
- R4: A good packet that arrives while disarmed is answered with `hs_code`=2'b10 (NAK). The byte count, the stored bytes and the receive flag do not change.
- R5: Reads of address 4 return the stored bytes in arrival order, one per read. A read there with no unread byte returns 0 and does not move the read position.
- R6: Writing 1 to bit 0 at address 1 clears the receive flag and leaves the buffer disarmed.
- R7: Writing 1 to bit 0 at address 2 (read-complete) sets the byte count to 0 and re-arms the buffer.
- R8: A good packet longer than 8 bytes is answered with NAK. Nothing is stored, the flag stays clear and the buffer stays armed.
- R9: A packet whose end marker has `rx_good`=0 gets no handshake, and count, flag and arming are unchanged.
- R10: An IN token while the stage is OUT moves it to status (2). A SETUP token returns it to idle (0).
- R11: `irq` equals the receive flag ANDed with the enable (address 0 write and read, bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_out | input | 1 | OUT token strobe |
| tok_in | input | 1 | IN token strobe |
| tok_setup | input | 1 | SETUP token strobe |
| rx_sop | input | 1 | First data byte marker |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_eop | input | 1 | End of data packet, in its own cycle after the last byte |
| rx_good | input | 1 | Packet integrity good, sampled with rx_eop |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | 2'b01 ACK, 2'b10 NAK |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data port) |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a buffer whose receive flag is clear but which is still disarmed. Only then does a NAK show that the flag and arming are separate. The bench gets there in three steps: it accepts a packet, clears only the flag, and offers a second packet. It then checks that the first packet's count is still reported. Overlong and corrupted packets are sent right after a re-arm, so that a wrongful store would show up as a changed count or a lost arming.

// File: rtl/ep0o_pkg.sv
package ep0o_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_OUT    = 2'd1,
    STG_STATUS = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_STORE = 2'd1,
    RX_DROP  = 2'd2
  } rx_state_e;

  localparam logic [1:0] HS_ACK = 2'b01;
  localparam logic [1:0] HS_NAK = 2'b10;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DONE = 3'd2;
  localparam logic [2:0] A_SIZE = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
endpackage

// File: rtl/ep0o_fifo.sv
module ep0o_fifo #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_cnt,
  input  logic          flush,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, ptr_q, ptr_d;
  logic          have_data;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign have_data = (ptr_q < cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    if (commit) begin
      cnt_d = commit_cnt;
      ptr_d = '0;
    end else if (flush) begin
      cnt_d = '0;
      ptr_d = '0;
    end else if (pop && have_data) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign cnt     = cnt_q;
  assign rd_data = have_data ? mem[ptr_q[IW-1:0]] : '0;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !commit) |=> (cnt_q == '0)); // R7
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !have_data && !commit && !flush) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/ep0o_rx_ctl.sv
module ep0o_rx_ctl
  import ep0o_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          stage_out,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rx_good,
  input  logic          rearm,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic [CW-1:0] commit_cnt,
  output logic          armed,
  output logic          hs_valid,
  output logic [1:0]    hs_code
);
  rx_state_e     state_q, state_d;
  logic [CW-1:0] idx_q, idx_d, cur_idx;
  logic          ovf_q, ovf_d;
  logic          armed_q, armed_d;
  logic          hsv_q, hsv_d;
  logic [1:0]    hsc_q, hsc_d;

  assign cur_idx    = rx_sop ? '0 : idx_q;
  assign wr_idx     = cur_idx[IW-1:0];
  assign wr_data    = rx_data;
  assign commit_cnt = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ovf_d   = ovf_q;
    armed_d = armed_q;
    hsv_d   = 1'b0;
    hsc_d   = hsc_q;
    wr_en   = 1'b0;
    commit  = 1'b0;
    if (rearm) armed_d = 1'b1;
    case (state_q)
      RX_IDLE: begin
        if (tok_out && stage_out) begin
          state_d = armed_q ? RX_STORE : RX_DROP;
          idx_d   = '0;
          ovf_d   = 1'b0;
        end
      end
      RX_STORE: begin
        if (rx_valid) begin
          if (cur_idx < CW'(DEPTH)) begin
            wr_en = 1'b1;
            idx_d = cur_idx + 1'b1;
          end else begin
            ovf_d = 1'b1;
            idx_d = cur_idx;
          end
        end
        if (rx_eop) begin
          state_d = RX_IDLE;
          if (rx_good) begin
            hsv_d = 1'b1;
            if (!ovf_q) begin
              hsc_d   = HS_ACK;
              commit  = 1'b1;
              armed_d = 1'b0;
            end else begin
              hsc_d = HS_NAK;
            end
          end
        end
      end
      RX_DROP: begin
        if (rx_eop) begin
          state_d = RX_IDLE;
          if (rx_good) begin
            hsv_d = 1'b1;
            hsc_d = HS_NAK;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      ovf_q   <= 1'b0;
      armed_q <= 1'b1;
      hsv_q   <= 1'b0;
      hsc_q   <= 2'b00;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ovf_q   <= ovf_d;
      armed_q <= armed_d;
      hsv_q   <= hsv_d;
      hsc_q   <= hsc_d;
    end
  end

  assign armed    = armed_q;
  assign hs_valid = hsv_q;
  assign hs_code  = hsc_q;

  AST_ACK_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (hsv_q && hsc_q == HS_ACK) |-> $past(armed_q)); // R3
  AST_HS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hsv_q |-> (hsc_q == HS_ACK || hsc_q == HS_NAK)); // R4
  AST_HS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hsv_q |=> !hsv_q); // R3
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DROP) |-> !wr_en); // R4
endmodule

// File: rtl/ep0o_stage.sv
module ep0o_stage
  import ep0o_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_out,
  input  logic       tok_in,
  input  logic       tok_setup,
  output logic [1:0] stage
);
  stage_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (tok_setup)                          stage_d = STG_IDLE;
    else if (tok_in && stage_q == STG_OUT)  stage_d = STG_STATUS;
    else if (sel_out)                       stage_d = STG_OUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= STG_IDLE;
    else        stage_q <= stage_d;
  end

  assign stage = stage_q;

  AST_IN_ENDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_OUT && tok_in && !tok_setup) |=> (stage_q == STG_STATUS)); // R10
  AST_SETUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (stage_q == STG_IDLE)); // R10
endmodule

// File: rtl/ep0o_regs.sv
module ep0o_regs
  import ep0o_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    wdata,
  input  logic          flag_set,
  input  logic [1:0]    stage,
  input  logic          armed,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] rdata,
  output logic          sel_out,
  output logic          flag_clr,
  output logic          rearm,
  output logic          pop,
  output logic          irq
);
  logic flag_q, flag_d;
  logic ien_q, ien_d;
  logic wr_ctrl;

  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign sel_out  = wr_ctrl && wdata[0];
  assign flag_clr = wr && (addr == A_STAT) && wdata[0];
  assign rearm    = wr && (addr == A_DONE) && wdata[0];
  assign pop      = rd && (addr == A_DATA);

  always_comb begin
    ien_d  = wr_ctrl ? wdata[1] : ien_q;
    flag_d = flag_q;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[3:2] = stage;
        rdata[1]   = ien_q;
      end
      A_STAT: begin
        rdata[0] = flag_q;
        rdata[1] = armed;
      end
      A_SIZE:  rdata[CW-1:0] = cnt;
      A_DATA:  rdata = rd_data;
      default: rdata = '0;
    endcase
  end

  assign irq = flag_q & ien_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag_q); // R3
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !flag_q); // R6
endmodule

// File: rtl/ep0_out_rxbuf.sv
module ep0_out_rxbuf
  import ep0o_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          tok_in,
  input  logic          tok_setup,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rx_good,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_ni;
  logic          wr_en, commit, armed, sel_out, flag_clr, rearm, pop;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data, rd_data;
  logic [CW-1:0] commit_cnt, cnt;
  logic [1:0]    stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ep0o_stage u_stage (
    .clk(clk), .rst_n(rst_ni), .sel_out(sel_out), .tok_in(tok_in),
    .tok_setup(tok_setup), .stage(stage)
  );

  ep0o_rx_ctl #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_ni), .tok_out(tok_out),
    .stage_out(stage == STG_OUT), .rx_sop(rx_sop), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good), .rearm(rearm),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit),
    .commit_cnt(commit_cnt), .armed(armed), .hs_valid(hs_valid),
    .hs_code(hs_code)
  );

  ep0o_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .commit(commit), .commit_cnt(commit_cnt),
    .flush(rearm), .pop(pop), .cnt(cnt), .rd_data(rd_data)
  );

  ep0o_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .flag_set(commit), .stage(stage), .armed(armed),
    .cnt(cnt), .rd_data(rd_data), .rdata(reg_rdata), .sel_out(sel_out),
    .flag_clr(flag_clr), .rearm(rearm), .pop(pop), .irq(irq)
  );

  AST_CLR_KEEPS_DISARM: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_clr && !rearm && !armed) |=> !armed); // R6
  AST_REARM_ARMS: assert property (@(posedge clk) disable iff (!rst_ni)
    (rearm && !commit) |=> armed); // R7
  AST_IDLE_NO_HS: assert property (@(posedge clk) disable iff (!rst_ni)
    (tok_out && stage != STG_OUT && !hs_valid) |=> !hs_valid); // R2
endmodule

// File: tb/ep0_out_rxbuf_tb.sv
module ep0_out_rxbuf_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_out = 0, tok_in = 0, tok_setup = 0;
  logic       rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_good = 0;
  logic [7:0] rx_data = 0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [2:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ep0_out_rxbuf u_dut (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .tok_in(tok_in),
    .tok_setup(tok_setup), .rx_sop(rx_sop), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
    .hs_valid(hs_valid), .hs_code(hs_code), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] base, input logic good,
                          output logic v, output logic [1:0] c);
    @(negedge clk); tok_out = 1;
    @(negedge clk); tok_out = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_sop = (i == 0); rx_data = base + 8'(i);
      @(negedge clk);
    end
    rx_valid = 0; rx_sop = 0; rx_eop = 1; rx_good = good;
    @(negedge clk); rx_eop = 0; rx_good = 0;
    #1 v = hs_valid; c = hs_code;
  endtask

  task automatic expect_status(input string req, input logic [7:0] size,
                               input logic flag, input logic armd);
    logic [7:0] d;
    do_read(3'd3, d);
    chk(d == size, {req, " size"}, d, size);
    do_read(3'd1, d);
    chk(d[0] == flag, {req, " flag"}, d[0], flag);
    chk(d[1] == armd, {req, " armed"}, d[1], armd);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    expect_status("R1", 8'd0, 1'b0, 1'b1);
    do_read(3'd0, d);
    chk(d[3:2] == 2'd0, "R1 stage", d[3:2], 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_no_stage;
    logic v; logic [1:0] c; logic [7:0] d;
    send_pkt(3, 8'h10, 1'b1, v, c);
    chk(v == 1'b0, "R2 no handshake outside OUT stage", v, 0);
    expect_status("R2", 8'd0, 1'b0, 1'b1);
    do_write(3'd0, 2'b11);
    do_read(3'd0, d);
    chk(d[3:2] == 2'd1, "R2 stage OUT", d[3:2], 1);
  endtask

  task automatic t_accept;
    logic v; logic [1:0] c; logic [7:0] d;
    do_read(3'd4, d);
    chk(d == 8'h00, "R5 empty read", d, 0);
    send_pkt(5, 8'hA0, 1'b1, v, c);
    chk(v == 1'b1 && c == 2'b01, "R3 ACK", {v, c}, 3'b101);
    expect_status("R3", 8'd5, 1'b1, 1'b0);
    chk(irq == 1'b1, "R11 irq with enable", irq, 1);
    for (int i = 0; i < 5; i++) begin
      do_read(3'd4, d);
      chk(d == 8'hA0 + 8'(i), "R5 data order", d, 8'hA0 + i);
    end
    do_read(3'd4, d);
    chk(d == 8'h00, "R5 read past end", d, 0);
  endtask

  task automatic t_nak;
    logic v; logic [1:0] c;
    do_write(3'd1, 2'b01);
    expect_status("R6", 8'd5, 1'b0, 1'b0);
    chk(irq == 1'b0, "R11 irq follows flag", irq, 0);
    send_pkt(3, 8'h55, 1'b1, v, c);
    chk(v == 1'b1 && c == 2'b10, "R4 NAK while disarmed", {v, c}, 3'b110);
    expect_status("R4", 8'd5, 1'b0, 1'b0);
    do_write(3'd2, 2'b01);
    expect_status("R7", 8'd0, 1'b0, 1'b1);
  endtask

  task automatic t_overflow;
    logic v; logic [1:0] c; logic [7:0] d;
    send_pkt(9, 8'h30, 1'b1, v, c);
    chk(v == 1'b1 && c == 2'b10, "R8 NAK on 9 bytes", {v, c}, 3'b110);
    expect_status("R8", 8'd0, 1'b0, 1'b1);
    send_pkt(8, 8'hC0, 1'b1, v, c);
    chk(v == 1'b1 && c == 2'b01, "R3 ACK on 8 bytes", {v, c}, 3'b101);
    expect_status("R3 full", 8'd8, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      do_read(3'd4, d);
      chk(d == 8'hC0 + 8'(i), "R5 full data", d, 8'hC0 + i);
    end
    do_write(3'd1, 2'b01);
    do_write(3'd2, 2'b01);
  endtask

  task automatic t_bad;
    logic v; logic [1:0] c;
    send_pkt(4, 8'h70, 1'b0, v, c);
    chk(v == 1'b0, "R9 no handshake on bad packet", v, 0);
    expect_status("R9", 8'd0, 1'b0, 1'b1);
  endtask

  task automatic t_irq_off;
    logic v; logic [1:0] c;
    do_write(3'd0, 2'b00);
    send_pkt(2, 8'h01, 1'b1, v, c);
    chk(v == 1'b1 && c == 2'b01, "R11 ACK", {v, c}, 3'b101);
    expect_status("R11", 8'd2, 1'b1, 1'b0);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
  endtask

  task automatic t_stage;
    logic [7:0] d;
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    do_read(3'd0, d);
    chk(d[3:2] == 2'd2, "R10 IN ends OUT stage", d[3:2], 2);
    @(negedge clk); tok_setup = 1;
    @(negedge clk); tok_setup = 0;
    do_read(3'd0, d);
    chk(d[3:2] == 2'd0, "R10 SETUP to idle", d[3:2], 0);
  endtask

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_no_stage;
    t_accept;
    t_nak;
    t_overflow;
    t_bad;
    t_irq_off;
    t_stage;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule